// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

A first-in first-out buffer for 9-bit words that sits between two unrelated clock domains. A producer pushes words on the write clock and a consumer pulls them on the read clock. The write side is gated by two enable pins. The read side is also gated by two enable pins, and a separate output-enable pin marks whether the read data is to be driven. Each pointer crosses into the opposite domain as a Gray code through a two-flop synchroniser. Full and almost-full are therefore evaluated in the write domain, and empty and almost-empty in the read domain. Each side is guaranteed never to see more room or more data than actually exists.

The write side behaves as a stream with valid/ready semantics. `wr_en_a` is the valid strobe and `wr_ready` is the inverse of `wr_full`. A word offered while `wr_ready` is low is dropped rather than held, so the producer must watch `wr_ready` and hold the word itself. On the read side, a word leaves only when both read enables are high and `rd_empty` is low. The read data is registered and changes on the read-clock edge that performs the read.

The almost-empty and almost-full thresholds come from two offset registers that can be rewritten at run time. With the shared-pin variant selected (`LD_SHARED`=1), the second write enable acts as a load strobe. Each load strobe writes the word on `wr_data` into the next offset register in turn, and stores nothing in the FIFO. The depth parameter is intended for 64, 256, 512 or 1024 words.

Top module: `prog_flag_fifo`

## Requirements
- R1: With `LD_SHARED`=1, a write-clock edge with `wr_en_a`=1, `wr_en_b_ld`=0 and `wr_full`=0 stores `wr_data` as the newest word. `wr_ready` is always the inverse of `wr_full`.
- R2: A read-clock edge with `rd_en_a`=1, `rd_en_b`=1 and `rd_empty`=0 moves the oldest word onto `rd_data` at that edge. If either read enable is 0, `rd_data` and the FIFO contents are unchanged.
- R3: A write attempted while `wr_full`=1 is discarded. It neither overwrites a stored word nor adds one.
- R4: A read attempted while `rd_empty`=1 has no effect: `rd_data` holds its value and `rd_empty` stays 1.
- R5: `rd_empty` is 1 exactly when the read domain sees zero stored words. `wr_full` is 1 exactly when the write domain sees DEPTH stored words.
- R6: `rd_almost_empty` is 1 when the stored word count seen in the read domain is less than or equal to the almost-empty offset.
- R7: `wr_almost_full` is 1 when the stored word count seen in the write domain is at least DEPTH minus the almost-full offset.
- R8: With `LD_SHARED`=1, a write-clock edge with `wr_en_a`=1 and `wr_en_b_ld`=1 loads the low log2(DEPTH) bits of `wr_data` into an offset register and stores nothing in the FIFO. The first such edge after reset loads the almost-empty offset, the next loads the almost-full offset, and the order then alternates.
- R9: After reset both pointers are zero, both offsets are 7 and `rd_data` is 0. `rd_empty`=1, `rd_almost_empty`=1, `wr_full`=0 and `wr_almost_full`=0.
- R10: `rd_valid` follows `rd_oe` and marks whether `rd_data` is to be driven.
- R11: Words come out in the order written, including after the pointers wrap past DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous reset, active low, both domains |
| wr_data | input | DATA_W | Word to store, or offset value during a load |
| wr_en_a | input | 1 | First write enable (stream valid) |
| wr_en_b_ld | input | 1 | Second write enable, or offset load strobe when LD_SHARED=1 |
| wr_ready | output | 1 | Room available for a write |
| wr_full | output | 1 | FIFO holds DEPTH words |
| wr_almost_full | output | 1 | Count at or above the almost-full threshold |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| rd_oe | input | 1 | Output enable for the read data |
| rd_data | output | DATA_W | Registered read word |
| rd_valid | output | 1 | Read data is to be driven (stands for the high-impedance control) |
| rd_empty | output | 1 | No word available |
| rd_almost_empty | output | 1 | Count at or below the almost-empty threshold |

## Verification
The assertions assume that each enable pin changes only away from the edges of its own clock. They also assume that the offset registers are reloaded only while the read side is idle, because the almost-empty offset reaches the read domain through a plain multi-bit synchroniser. The bench drives every input on the falling edge of the clock that samples it. It performs loads only while no read is in progress, and it waits several cycles of both clocks before it compares any flag, so that every pointer crossing has settled.

// File: rtl/pff_pkg.sv
`timescale 1ns/1ps
package pff_pkg;
  localparam int unsigned PFF_DATA_W       = 9;
  localparam int unsigned PFF_OFFSET_RESET = 7;

  // which offset register the next load strobe writes
  typedef enum logic {
    LOAD_EMPTY_OFS = 1'b0,
    LOAD_FULL_OFS  = 1'b1
  } ofs_sel_e;
endpackage

// File: rtl/pff_sync2.sv
`timescale 1ns/1ps
module pff_sync2 #(
  parameter int unsigned W       = 1,
  parameter logic [63:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL[W-1:0];
      q      <= RST_VAL[W-1:0];
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/pff_store.sv
`timescale 1ns/1ps
module pff_store #(
  parameter int unsigned DW    = 9,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // output register: changes only on an accepted read
  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pff_wr_ctrl.sv
`timescale 1ns/1ps
module pff_wr_ctrl #(
  parameter int unsigned DW        = 9,
  parameter int unsigned DEPTH     = 64,
  parameter int unsigned AW        = 6,
  parameter int unsigned PW        = 7,
  parameter bit          LD_SHARED = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_a,
  input  logic          en_b_ld,
  input  logic [DW-1:0] din,
  input  logic [PW-1:0] rgray_async,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] wgray,
  output logic          put,
  output logic          full,
  output logic          afull,
  output logic [AW-1:0] ae_ofs,
  output logic [AW-1:0] af_ofs
);
  import pff_pkg::*;

  localparam logic [PW-1:0] DEPTH_P  = PW'(DEPTH);
  localparam logic [AW-1:0] OFS_INIT = AW'(PFF_OFFSET_RESET);

  logic          put_req;
  logic          load;
  ofs_sel_e      sel_q;
  logic [AW-1:0] din_ofs;
  logic [PW-1:0] rgray_s;
  logic [PW-1:0] rbin;
  logic [PW-1:0] level;

  generate
    if (LD_SHARED) begin : g_shared_pin
      assign load    = en_a & en_b_ld;
      assign put_req = en_a & ~en_b_ld;
    end else begin : g_dual_enable
      assign load    = 1'b0;
      assign put_req = en_a & en_b_ld;
    end
  endgenerate

  assign din_ofs = AW'(din);

  pff_sync2 #(.W(PW), .RST_VAL('0)) u_rptr_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (rgray_async),
    .q    (rgray_s)
  );

  for (genvar i = 0; i < PW; i++) begin : g_gray2bin
    assign rbin[i] = ^rgray_s[PW-1:i];
  end

  assign level = wptr - rbin;
  assign full  = (level == DEPTH_P);
  assign afull = (level >= (DEPTH_P - PW'(af_ofs)));
  assign put   = put_req & ~full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr   <= '0;
      wgray  <= '0;
      sel_q  <= LOAD_EMPTY_OFS;
      ae_ofs <= OFS_INIT;
      af_ofs <= OFS_INIT;
    end else begin
      if (put) wptr <= wptr + 1'b1;
      wgray <= wptr ^ (wptr >> 1);
      if (load) begin
        case (sel_q)
          LOAD_EMPTY_OFS: begin
            ae_ofs <= din_ofs;
            sel_q  <= LOAD_FULL_OFS;
          end
          default: begin
            af_ofs <= din_ofs;
            sel_q  <= LOAD_EMPTY_OFS;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/pff_rd_ctrl.sv
`timescale 1ns/1ps
module pff_rd_ctrl #(
  parameter int unsigned AW = 6,
  parameter int unsigned PW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_a,
  input  logic          en_b,
  input  logic [PW-1:0] wgray_async,
  input  logic [AW-1:0] ae_ofs_async,
  output logic [PW-1:0] rptr,
  output logic [PW-1:0] rgray,
  output logic          take,
  output logic          empty,
  output logic          aempty
);
  import pff_pkg::*;

  logic [PW-1:0] wgray_s;
  logic [PW-1:0] wbin;
  logic [AW-1:0] ae_ofs_s;
  logic [PW-1:0] level;

  pff_sync2 #(.W(PW), .RST_VAL('0)) u_wptr_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (wgray_async),
    .q    (wgray_s)
  );

  // offset is quasi-static: only reloaded while the read side is idle
  pff_sync2 #(.W(AW), .RST_VAL(64'(PFF_OFFSET_RESET))) u_ofs_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ae_ofs_async),
    .q    (ae_ofs_s)
  );

  for (genvar i = 0; i < PW; i++) begin : g_gray2bin
    assign wbin[i] = ^wgray_s[PW-1:i];
  end

  assign level  = wbin - rptr;
  assign empty  = (level == '0);
  assign aempty = (level <= PW'(ae_ofs_s));
  assign take   = en_a & en_b & ~empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      rgray <= '0;
    end else begin
      if (take) rptr <= rptr + 1'b1;
      rgray <= rptr ^ (rptr >> 1);
    end
  end
endmodule

// File: rtl/prog_flag_fifo.sv
`timescale 1ns/1ps
module prog_flag_fifo #(
  parameter int unsigned DATA_W    = pff_pkg::PFF_DATA_W,
  parameter int unsigned DEPTH     = 64,
  parameter bit          LD_SHARED = 1'b1
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en_a,
  input  logic              wr_en_b_ld,
  output logic              wr_ready,
  output logic              wr_full,
  output logic              wr_almost_full,
  input  logic              rd_en_a,
  input  logic              rd_en_b,
  input  logic              rd_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_empty,
  output logic              rd_almost_empty
);
  localparam int unsigned ADDR_W = $clog2(DEPTH);
  localparam int unsigned PTR_W  = ADDR_W + 1;

  logic [PTR_W-1:0]  wr_ptr, wr_gray;
  logic [PTR_W-1:0]  rd_ptr, rd_gray;
  logic              put, take;
  logic [ADDR_W-1:0] ae_ofs, af_ofs;

  pff_wr_ctrl #(
    .DW(DATA_W), .DEPTH(DEPTH), .AW(ADDR_W), .PW(PTR_W), .LD_SHARED(LD_SHARED)
  ) u_wr (
    .clk        (wr_clk),
    .rst_n      (rst_n),
    .en_a       (wr_en_a),
    .en_b_ld    (wr_en_b_ld),
    .din        (wr_data),
    .rgray_async(rd_gray),
    .wptr       (wr_ptr),
    .wgray      (wr_gray),
    .put        (put),
    .full       (wr_full),
    .afull      (wr_almost_full),
    .ae_ofs     (ae_ofs),
    .af_ofs     (af_ofs)
  );

  pff_rd_ctrl #(.AW(ADDR_W), .PW(PTR_W)) u_rd (
    .clk         (rd_clk),
    .rst_n       (rst_n),
    .en_a        (rd_en_a),
    .en_b        (rd_en_b),
    .wgray_async (wr_gray),
    .ae_ofs_async(ae_ofs),
    .rptr        (rd_ptr),
    .rgray       (rd_gray),
    .take        (take),
    .empty       (rd_empty),
    .aempty      (rd_almost_empty)
  );

  pff_store #(.DW(DATA_W), .DEPTH(DEPTH), .AW(ADDR_W)) u_mem (
    .wclk (wr_clk),
    .we   (put),
    .waddr(wr_ptr[ADDR_W-1:0]),
    .wdata(wr_data),
    .rclk (rd_clk),
    .rst_n(rst_n),
    .re   (take),
    .raddr(rd_ptr[ADDR_W-1:0]),
    .rdata(rd_data)
  );

  assign wr_ready = ~wr_full;
  assign rd_valid = rd_oe;

  // the almost-full offset is used only inside the write controller
  logic af_ofs_unused;
  assign af_ofs_unused = ^af_ofs;
endmodule

// File: rtl/pff_checker.sv
`timescale 1ns/1ps
module pff_checker #(
  parameter int unsigned DW        = 9,
  parameter int unsigned PW        = 7,
  parameter bit          LD_SHARED = 1'b1
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          wr_en_a,
  input logic          wr_en_b_ld,
  input logic          wr_full,
  input logic          wr_almost_full,
  input logic          rd_en_a,
  input logic          rd_en_b,
  input logic          rd_empty,
  input logic          rd_almost_empty,
  input logic [DW-1:0] rd_data,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr
);
  logic put_try, load_try;
  assign put_try  = LD_SHARED ? (wr_en_a & ~wr_en_b_ld) : (wr_en_a & wr_en_b_ld);
  assign load_try = LD_SHARED & wr_en_a & wr_en_b_ld;

  // R1: an accepted write advances the write pointer by one
  assert_write_advances_R1: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (put_try && !wr_full) |=> (wr_ptr == PW'($past(wr_ptr) + 1'b1)));

  // R3: a write against a full FIFO leaves the pointer alone
  assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (put_try && wr_full) |=> (wr_ptr == $past(wr_ptr)));

  // R8: a load strobe never stores a word
  assert_load_no_store_R8: assert property (@(posedge wr_clk) disable iff (!rst_n)
    load_try |=> (wr_ptr == $past(wr_ptr)));

  // R4: a read against an empty FIFO changes nothing
  assert_no_underflow_R4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_empty && rd_en_a && rd_en_b) |=> ($stable(rd_data) && $stable(rd_ptr)));

  // R2: both read enables are needed to move the output
  assert_paired_read_R2: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!rd_en_a || !rd_en_b) |=> ($stable(rd_data) && $stable(rd_ptr)));

  // R6: empty implies almost empty
  assert_empty_in_almost_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_empty |-> rd_almost_empty);

  // R7: full implies almost full
  assert_full_in_almost_R7: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_full |-> wr_almost_full);
endmodule

bind prog_flag_fifo pff_checker #(
  .DW(DATA_W), .PW(PTR_W), .LD_SHARED(LD_SHARED)
) u_pff_checker (
  .wr_clk         (wr_clk),
  .rd_clk         (rd_clk),
  .rst_n          (rst_n),
  .wr_en_a        (wr_en_a),
  .wr_en_b_ld     (wr_en_b_ld),
  .wr_full        (wr_full),
  .wr_almost_full (wr_almost_full),
  .rd_en_a        (rd_en_a),
  .rd_en_b        (rd_en_b),
  .rd_empty       (rd_empty),
  .rd_almost_empty(rd_almost_empty),
  .rd_data        (rd_data),
  .wr_ptr         (wr_ptr),
  .rd_ptr         (rd_ptr)
);

// File: tb/prog_flag_fifo_bench.sv
`timescale 1ns/1ps
module prog_flag_fifo_bench;
  localparam int DW    = 9;
  localparam int DEPTH = 64;

  logic          wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_en_a = 1'b0, wr_en_b_ld = 1'b0;
  logic          rd_en_a = 1'b0, rd_en_b = 1'b0, rd_oe = 1'b0;
  logic          wr_ready, wr_full, wr_almost_full;
  logic [DW-1:0] rd_data;
  logic          rd_valid, rd_empty, rd_almost_empty;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #10 wr_clk = ~wr_clk;   // 50 MHz write clock
  always #13 rd_clk = ~rd_clk;   // unrelated read clock

  prog_flag_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .LD_SHARED(1'b1)) u_prog_flag_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_data(wr_data), .wr_en_a(wr_en_a), .wr_en_b_ld(wr_en_b_ld),
    .wr_ready(wr_ready), .wr_full(wr_full), .wr_almost_full(wr_almost_full),
    .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .rd_oe(rd_oe),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_empty(rd_empty),
    .rd_almost_empty(rd_almost_empty)
  );

  function automatic int pat(input int i);
    return (i * 37 + 5) % 512;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge wr_clk);
  endtask

  task automatic write_word(input int d);
    @(negedge wr_clk);
    wr_data = DW'(d); wr_en_a = 1'b1; wr_en_b_ld = 1'b0;
    @(negedge wr_clk);
    wr_en_a = 1'b0;
  endtask

  task automatic load_word(input int d);
    @(negedge wr_clk);
    wr_data = DW'(d); wr_en_a = 1'b1; wr_en_b_ld = 1'b1;
    @(negedge wr_clk);
    wr_en_a = 1'b0; wr_en_b_ld = 1'b0;
  endtask

  task automatic read_word(output int d);
    @(negedge rd_clk);
    rd_en_a = 1'b1; rd_en_b = 1'b1;
    @(negedge rd_clk);
    rd_en_a = 1'b0; rd_en_b = 1'b0;
    d = int'(rd_data);
  endtask

  task automatic t_reset();
    check("R9 empty", int'(rd_empty), 1);
    check("R9 almost empty", int'(rd_almost_empty), 1);
    check("R9 full", int'(wr_full), 0);
    check("R9 almost full", int'(wr_almost_full), 0);
    check("R9 rd_data", int'(rd_data), 0);
    check("R1 ready after reset", int'(wr_ready), 1);
  endtask

  task automatic t_output_enable();
    rd_oe = 1'b0; #1;
    check("R10 valid low", int'(rd_valid), 0);
    rd_oe = 1'b1; #1;
    check("R10 valid high", int'(rd_valid), 1);
  endtask

  task automatic t_default_offsets();
    int got;
    for (int i = 0; i < 7; i++) write_word(200 + i);
    settle();
    check("R6 default offset 7 words", int'(rd_almost_empty), 1);
    check("R7 default offset 7 words", int'(wr_almost_full), 0);
    write_word(207);
    settle();
    check("R6 default offset 8 words", int'(rd_almost_empty), 0);
    check("R5 not empty", int'(rd_empty), 0);
    for (int i = 0; i < 8; i++) begin
      read_word(got);
      check("R2 order", got, 200 + i);
    end
    check("R5 empty after drain", int'(rd_empty), 1);
  endtask

  task automatic t_load_offsets();
    load_word(3);   // almost-empty offset
    load_word(5);   // almost-full offset
    settle();
    check("R8 load stores nothing", int'(rd_empty), 1);
    check("R8 ready unchanged", int'(wr_ready), 1);
  endtask

  task automatic t_fill();
    for (int n = 1; n <= DEPTH; n++) begin
      write_word(pat(n));
      settle();
      check("R6 almost empty during fill", int'(rd_almost_empty), (n <= 3) ? 1 : 0);
      check("R7 almost full during fill", int'(wr_almost_full), (n >= DEPTH - 5) ? 1 : 0);
      check("R5 full during fill", int'(wr_full), (n == DEPTH) ? 1 : 0);
      check("R1 ready during fill", int'(wr_ready), (n == DEPTH) ? 0 : 1);
    end
  endtask

  task automatic t_overflow_drain();
    int got;
    write_word(9'h1AA);
    settle();
    check("R3 still full", int'(wr_full), 1);
    for (int n = 1; n <= DEPTH; n++) begin
      read_word(got);
      check("R3 contents intact", got, pat(n));
    end
    settle();
    check("R3 no extra word", int'(rd_empty), 1);
    check("R5 not full after drain", int'(wr_full), 0);
  endtask

  task automatic t_underflow();
    int got;
    int last;
    last = int'(rd_data);
    read_word(got);
    check("R4 data held", got, last);
    check("R4 still empty", int'(rd_empty), 1);
  endtask

  task automatic t_paired_read();
    int got;
    int last;
    write_word(9'h055);
    settle();
    last = int'(rd_data);
    @(negedge rd_clk); rd_en_a = 1'b1; rd_en_b = 1'b0;
    @(negedge rd_clk); rd_en_a = 1'b0;
    check("R2 single enable a", int'(rd_data), last);
    @(negedge rd_clk); rd_en_b = 1'b1;
    @(negedge rd_clk); rd_en_b = 1'b0;
    check("R2 single enable b", int'(rd_data), last);
    check("R2 word kept", int'(rd_empty), 0);
    read_word(got);
    check("R2 paired read", got, 9'h055);
  endtask

  task automatic t_wrap();
    int got;
    for (int i = 0; i < 40; i++) write_word(pat(100 + i));
    settle();
    for (int i = 0; i < 40; i++) begin
      read_word(got);
      check("R11 order across wrap", got, pat(100 + i));
    end
    check("R11 empty after wrap", int'(rd_empty), 1);
  endtask

  task automatic t_reload();
    load_word(0);
    load_word(0);
    settle();
    check("R8 reload stores nothing", int'(rd_empty), 1);
    check("R6 offset 0 at 0 words", int'(rd_almost_empty), 1);
    write_word(9'h0F0);
    settle();
    check("R6 offset 0 at 1 word", int'(rd_almost_empty), 0);
    check("R7 offset 0 at 1 word", int'(wr_almost_full), 0);
    load_word(63);
    load_word(63);
    settle();
    check("R8 order ae first", int'(rd_almost_empty), 1);
    check("R8 order af second", int'(wr_almost_full), 1);
  endtask

  initial begin
    repeat (5) @(negedge wr_clk);
    rst_n = 1'b1;
    repeat (4) @(negedge wr_clk);
    t_reset();
    t_output_enable();
    t_default_offsets();
    t_load_offsets();
    t_fill();
    t_overflow_drain();
    t_underflow();
    t_paired_read();
    t_wrap();
    t_reload();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge wr_clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule